// File: doc/BRIEF.md
# Four-Stage Watchdog Timer

This block watches over software that must prove it is alive. One counter runs through four stages in turn. Each stage has its own timeout and its own expiry action: do nothing, raise an interrupt, reset one or both CPUs, reset the system, or reset the always-on domain. Software restarts the sequence by feeding the watchdog. If it stops feeding, the stages expire one after another, so a missed feed can first cause an interrupt and then escalating resets.

Configuration goes through a small register port. Configuration writes take effect only while a key register holds a fixed unlock word. A 2-bit strap scales the stage-0 timeout. A sleep input can freeze counting. A boot-mode bit, set out of reset, keeps the watchdog running even when its main enable is clear. Reset outputs are single pulses. Their widths come from 3-bit length codes, which are converted into clock cycles using the clock-period parameter. The block's clock is the slow clock that sets the chip-reset width.

Register map (4-bit word address, 32-bit data):
- 0 CTRL: bit0 run enable, bit1 boot enable, bit2 pause-in-sleep, bit3 chip-reset enable, bit4 CPU0 enable, bit5 CPU1 enable, bits[8:6] CPU length code, bits[11:9] system length code, bits[19:12] chip width.
- 1 ACTS: stage i action in bits [3i+2:3i].
- 2..5: stage 0..3 timeouts.
- 6 FEED: bit0 feeds.
- 7 KEY: the key value.
- 8 IRQ_EN: bit0.
- 9 IRQ_ST: bit0, read-only.
- 10 IRQ_CLR: bit0, write 1 to clear.

Top module: `staged_watchdog`

## Requirements
- R1: Action codes: 0 = off, 1 = set interrupt status, 2 = CPU reset, 3 = system reset, 4 = always-on reset; 5, 6 and 7 act as off. An action fires only on the expiry of the stage that holds it, and the always-on pulse uses the system length code.
- R2: The stage-0 limit is TMO0 × 2^(1+dly_sel_i). Stages 1 to 3 use their programmed value directly.
- R3: A stage expires after limit enabled cycles counted from its start. The stage then advances by one and wraps from 3 to 0. A stage with action off still expires and advances.
- R4: Writing 1 to FEED bit0 clears the count and returns the sequencer to stage 0. It works whether or not the registers are unlocked.
- R5: Writes to CTRL, ACTS, the timeouts and IRQ_EN take effect only while KEY holds 0x50D83AA1. Writing any other value to KEY locks them again.
- R6: Reset values are as follows: CTRL = 0x2 (boot enable only), all actions off, every timeout equal to TMO_RESET, and the key locked. With boot enable set, the watchdog counts and fires even when run enable is 0. With both enables 0, the count is held at zero.
- R7: Length codes 0 to 7 select 100, 200, 300, 400, 500, 800, 1600 and 3200 ns. The pulse lasts ceil(ns / period) cycles, with a minimum of one cycle.
- R8: A CPU-reset action pulses cpu_rst_o[k] only when CTRL bit 4+k is set.
- R9: While pause-in-sleep is set and sleep_i is high, the count holds. With pause-in-sleep clear, sleep_i has no effect.
- R10: With chip-reset enable set, any CPU, system or always-on action also pulses chip_rst_o for the chip width in cycles (0 counts as 1).
- R11: irq_o is IRQ_ST AND IRQ_EN. IRQ_ST stays set until bit0 is written to IRQ_CLR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| sleep_i | input | 1 | Sleep indication |
| dly_sel_i | input | 2 | Stage-0 scale strap |
| irq_o | output | 1 | Interrupt line |
| cpu_rst_o | output | 2 | Per-CPU reset pulses |
| sys_rst_o | output | 1 | System reset pulse |
| aon_rst_o | output | 1 | Always-on domain reset pulse |
| chip_rst_o | output | 1 | Chip reset pulse |

## Verification
On every cycle, the assertions check the following: the stage only steps forward by one or returns to zero, locked configuration never changes, a held count stays held while paused in sleep, interrupt status only rises from an interrupt-stage expiry, and a CPU pulse only starts when that CPU is enabled. Only the bench's scenarios can show the absolute timing. These cover:
- the strap-scaled stage-0 limit for every strap value;
- the summed sequence times and the wrap back to stage 0;
- every pulse-length code converted to cycles;
- the sleep pause stretching a stage by exactly its length;
- boot mode firing with the run enable off.

// File: rtl/wdt_pkg.sv
// Shared constants, register addresses, control layout and length-code
// conversion for the four-stage watchdog. Assumes four stages and two CPUs.
package wdt_pkg;

    localparam int NUM_STG = 4;
    localparam int NUM_CPU = 2;
    localparam int STG_W   = $clog2(NUM_STG);
    localparam int ADDR_W  = 4;
    localparam int PW      = 16;
    localparam int NUM_LEN = 8;

    localparam logic [ADDR_W-1:0] A_CTRL   = 4'd0;
    localparam logic [ADDR_W-1:0] A_ACTS   = 4'd1;
    localparam logic [ADDR_W-1:0] A_TMO0   = 4'd2;
    localparam logic [ADDR_W-1:0] A_FEED   = 4'd6;
    localparam logic [ADDR_W-1:0] A_KEY    = 4'd7;
    localparam logic [ADDR_W-1:0] A_IRQEN  = 4'd8;
    localparam logic [ADDR_W-1:0] A_IRQST  = 4'd9;
    localparam logic [ADDR_W-1:0] A_IRQCLR = 4'd10;

    typedef enum logic [2:0] {
        ACT_OFF = 3'd0,
        ACT_IRQ = 3'd1,
        ACT_CPU = 3'd2,
        ACT_SYS = 3'd3,
        ACT_AON = 3'd4
    } act_e;

    typedef struct packed {
        logic [7:0]         chip_w;
        logic [2:0]         sys_len;
        logic [2:0]         cpu_len;
        logic [NUM_CPU-1:0] cpu_en;
        logic               chip_en;
        logic               pause_slp;
        logic               boot_en;
        logic               run_en;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    // Whole clock cycles for a length code, rounded up, at least one.
    function automatic logic [PW-1:0] len_cycles(input int code, input int period_ps);
        int ns;
        int cyc;
        case (code)
            0:       ns = 100;
            1:       ns = 200;
            2:       ns = 300;
            3:       ns = 400;
            4:       ns = 500;
            5:       ns = 800;
            6:       ns = 1600;
            default: ns = 3200;
        endcase
        cyc = (ns * 1000 + period_ps - 1) / period_ps;
        if (cyc < 1) cyc = 1;
        return PW'(cyc);
    endfunction

endpackage

// File: rtl/wdt_regs.sv
// Register file of the watchdog. It holds the control, action, timeout,
// key and interrupt registers. Configuration writes need the key to be
// unlocked; key, feed and interrupt clear are always writable.
// Assumes one write per cycle and a combinational read path.
module wdt_regs
    import wdt_pkg::*;
#(
    parameter int          TMO_W     = 32,
    parameter logic [31:0] TMO_RESET = 32'd100000,
    parameter logic [31:0] KEY       = 32'h50D83AA1
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             we,
    input  logic [ADDR_W-1:0]                addr,
    input  logic [31:0]                      wdata,
    input  logic                             fire_irq,
    output logic [31:0]                      rdata,
    output ctrl_t                            ctrl,
    output logic [NUM_STG-1:0][2:0]          acts,
    output logic [NUM_STG-1:0][TMO_W-1:0]    tmo,
    output logic                             feed,
    output logic                             irq_st,
    output logic                             irq_en,
    output logic                             unlocked
);

    logic [31:0] key_q;
    logic        cfg_wr;
    logic        clr_wr;

    assign unlocked = (key_q == KEY);
    assign cfg_wr   = we && unlocked;
    assign feed     = we && (addr == A_FEED) && wdata[0];
    assign clr_wr   = we && (addr == A_IRQCLR) && wdata[0];

    // Key register: any write replaces the stored word.
    always_ff @(posedge clk) begin
        if (!rst_n)                      key_q <= '0;
        else if (we && addr == A_KEY)    key_q <= wdata;
    end

    // Control register, boot enable set out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl         <= '0;
            ctrl.boot_en <= 1'b1;
        end else if (cfg_wr && addr == A_CTRL) begin
            ctrl <= ctrl_t'(wdata[CTRL_W-1:0]);
        end
    end

    // Stage action codes.
    always_ff @(posedge clk) begin
        if (!rst_n)                         acts <= '0;
        else if (cfg_wr && addr == A_ACTS)  acts <= wdata[NUM_STG*3-1:0];
    end

    // One timeout register per stage.
    for (genvar g = 0; g < NUM_STG; g++) begin : g_tmo
        always_ff @(posedge clk) begin
            if (!rst_n)
                tmo[g] <= TMO_W'(TMO_RESET);
            else if (cfg_wr && addr == A_TMO0 + ADDR_W'(g))
                tmo[g] <= wdata[TMO_W-1:0];
        end
    end

    // Interrupt enable.
    always_ff @(posedge clk) begin
        if (!rst_n)                          irq_en <= 1'b0;
        else if (cfg_wr && addr == A_IRQEN)  irq_en <= wdata[0];
    end

    // Interrupt status: an expiry sets it and wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)        irq_st <= 1'b0;
        else if (fire_irq) irq_st <= 1'b1;
        else if (clr_wr)   irq_st <= 1'b0;
    end

    // Read multiplexer.
    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_STG; i++)
            if (addr == A_TMO0 + ADDR_W'(i)) rdata = 32'(tmo[i]);
        case (addr)
            A_CTRL:  rdata = 32'(ctrl);
            A_ACTS:  rdata = 32'(acts);
            A_KEY:   rdata = key_q;
            A_IRQEN: rdata = 32'(irq_en);
            A_IRQST: rdata = 32'(irq_st);
            default: ;
        endcase
    end

endmodule

// File: rtl/wdt_seq.sv
// Stage sequencer and counter. A single counter times the current stage
// against its limit; stage 0 is scaled by the strap. On expiry it decodes
// the stage action into one-cycle fire strobes, clears the count and
// advances the stage, wrapping after the last one.
module wdt_seq
    import wdt_pkg::*;
#(
    parameter int TMO_W = 32
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          run_en,
    input  logic                          boot_en,
    input  logic                          pause_slp,
    input  logic                          sleep_i,
    input  logic [1:0]                    dly_sel,
    input  logic                          feed,
    input  logic [NUM_STG-1:0][TMO_W-1:0] tmo,
    input  logic [NUM_STG-1:0][2:0]       acts,
    output logic                          fire_irq,
    output logic                          fire_cpu,
    output logic                          fire_sys,
    output logic                          fire_aon,
    output logic [STG_W-1:0]              stage_q,
    output logic [TMO_W+3:0]              count_q
);

    localparam int CNT_W = TMO_W + 4;

    logic [CNT_W-1:0] limit;
    logic [2:0]       shamt;
    logic [2:0]       cur_act;
    logic             armed;
    logic             active;
    logic             hit;

    // Limit of the current stage, stage 0 scaled by 2^(1+strap).
    always_comb begin
        shamt = (stage_q == '0) ? (3'(dly_sel) + 3'd1) : 3'd0;
        limit = CNT_W'(tmo[stage_q]) << shamt;
    end

    assign armed   = run_en || boot_en;
    assign active  = armed && !(pause_slp && sleep_i) && !feed;
    assign hit     = active && ({1'b0, count_q} + 1'b1 >= {1'b0, limit});
    assign cur_act = acts[stage_q];

    // Action decode, valid only in the expiry cycle.
    always_comb begin
        fire_irq = hit && (cur_act == ACT_IRQ);
        fire_cpu = hit && (cur_act == ACT_CPU);
        fire_sys = hit && (cur_act == ACT_SYS);
        fire_aon = hit && (cur_act == ACT_AON);
    end

    // Counter and stage pointer.
    always_ff @(posedge clk) begin
        if (!rst_n || feed || !armed) begin
            count_q <= '0;
            stage_q <= '0;
        end else if (hit) begin
            count_q <= '0;
            stage_q <= (stage_q == STG_W'(NUM_STG - 1)) ? '0 : stage_q + 1'b1;
        end else if (active) begin
            count_q <= count_q + 1'b1;
        end
    end

endmodule

// File: rtl/wdt_pulse.sv
// Pulse stretcher: a trigger loads the length and the output stays high
// until the count reaches zero. A new trigger reloads it. Assumes the
// length is at least one.
module wdt_pulse #(
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trig,
    input  logic [LEN_W-1:0] len,
    output logic             pulse
);

    logic [LEN_W-1:0] cnt_q;

    // Load on trigger, count down otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)           cnt_q <= '0;
        else if (trig)        cnt_q <= len;
        else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
    end

    assign pulse = (cnt_q != '0);

endmodule

// File: rtl/staged_watchdog.sv
// Top of the four-stage watchdog. It joins the register file, the
// sequencer and the reset pulse stretchers. Length codes become cycle
// counts through a table folded from CLK_PERIOD_PS.
module staged_watchdog
    import wdt_pkg::*;
#(
    parameter int          TMO_W         = 32,
    parameter int          CLK_PERIOD_PS = 8000,
    parameter logic [31:0] TMO_RESET     = 32'd100000,
    parameter logic [31:0] KEY           = 32'h50D83AA1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_we,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    input  logic               sleep_i,
    input  logic [1:0]         dly_sel_i,
    output logic               irq_o,
    output logic [NUM_CPU-1:0] cpu_rst_o,
    output logic               sys_rst_o,
    output logic               aon_rst_o,
    output logic               chip_rst_o
);

    localparam int CNT_W = TMO_W + 4;

    ctrl_t                         ctrl;
    logic [NUM_STG-1:0][2:0]       acts;
    logic [NUM_STG-1:0][TMO_W-1:0] tmo;
    logic                          feed;
    logic                          irq_st;
    logic                          irq_en;
    logic                          unlocked;
    logic                          fire_irq;
    logic                          fire_cpu;
    logic                          fire_sys;
    logic                          fire_aon;
    logic [STG_W-1:0]              stage_q;
    logic [CNT_W-1:0]              count_q;
    logic [PW-1:0]                 len_tab [NUM_LEN];
    logic [PW-1:0]                 cpu_len;
    logic [PW-1:0]                 sys_len;
    logic [PW-1:0]                 chip_len;

    wdt_regs #(.TMO_W(TMO_W), .TMO_RESET(TMO_RESET), .KEY(KEY)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
        .fire_irq(fire_irq), .rdata(reg_rdata), .ctrl(ctrl), .acts(acts), .tmo(tmo),
        .feed(feed), .irq_st(irq_st), .irq_en(irq_en), .unlocked(unlocked)
    );

    wdt_seq #(.TMO_W(TMO_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .run_en(ctrl.run_en), .boot_en(ctrl.boot_en),
        .pause_slp(ctrl.pause_slp), .sleep_i(sleep_i), .dly_sel(dly_sel_i),
        .feed(feed), .tmo(tmo), .acts(acts), .fire_irq(fire_irq),
        .fire_cpu(fire_cpu), .fire_sys(fire_sys), .fire_aon(fire_aon),
        .stage_q(stage_q), .count_q(count_q)
    );

    // Constant table of pulse lengths in cycles.
    for (genvar g = 0; g < NUM_LEN; g++) begin : g_len
        assign len_tab[g] = len_cycles(g, CLK_PERIOD_PS);
    end

    assign cpu_len  = len_tab[ctrl.cpu_len];
    assign sys_len  = len_tab[ctrl.sys_len];
    assign chip_len = (ctrl.chip_w == '0) ? PW'(1) : PW'(ctrl.chip_w);

    assign irq_o = irq_st && irq_en;

    // One stretcher per CPU, gated by that CPU's enable.
    for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
        wdt_pulse #(.LEN_W(PW)) u_cpu (
            .clk(clk), .rst_n(rst_n), .trig(fire_cpu && ctrl.cpu_en[c]),
            .len(cpu_len), .pulse(cpu_rst_o[c])
        );
    end

    wdt_pulse #(.LEN_W(PW)) u_sys (
        .clk(clk), .rst_n(rst_n), .trig(fire_sys), .len(sys_len), .pulse(sys_rst_o)
    );

    wdt_pulse #(.LEN_W(PW)) u_aon (
        .clk(clk), .rst_n(rst_n), .trig(fire_aon), .len(sys_len), .pulse(aon_rst_o)
    );

    wdt_pulse #(.LEN_W(PW)) u_chip (
        .clk(clk), .rst_n(rst_n),
        .trig(ctrl.chip_en && (fire_cpu || fire_sys || fire_aon)),
        .len(chip_len), .pulse(chip_rst_o)
    );

endmodule

// File: rtl/wdt_chk.sv
// Checker for the watchdog, bound to the top module. It observes the
// stage pointer, counter, key state, configuration and reset outputs.
module wdt_chk
    import wdt_pkg::*;
#(
    parameter int CNT_W = 36
) (
    input logic               clk,
    input logic               rst_n,
    input logic [STG_W-1:0]   stage_q,
    input logic [CNT_W-1:0]   count_q,
    input logic               unlocked,
    input ctrl_t              ctrl,
    input logic               feed,
    input logic               sleep_i,
    input logic               irq_st,
    input logic               fire_irq,
    input logic [NUM_CPU-1:0] cpu_rst_o
);

    // R3
    stage_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(stage_q) |-> (stage_q == '0) || (stage_q == $past(stage_q) + 1'b1));

    // R5
    locked_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !unlocked |=> $stable(ctrl));

    // R9
    sleep_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.pause_slp && sleep_i && !feed && (ctrl.run_en || ctrl.boot_en))
        |=> $stable(count_q));

    // R11
    irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_st) |-> $past(fire_irq));

    for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu_chk
        // R8
        cpu_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(cpu_rst_o[c]) |-> $past(ctrl.cpu_en[c]));
    end

endmodule

bind staged_watchdog wdt_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .stage_q(stage_q), .count_q(count_q),
    .unlocked(unlocked), .ctrl(ctrl), .feed(feed), .sleep_i(sleep_i),
    .irq_st(irq_st), .fire_irq(fire_irq), .cpu_rst_o(cpu_rst_o)
);

// File: tb/sim_staged_watchdog.sv
// Bench for the four-stage watchdog: sweeps strap values, length codes and
// CPU masks, plus scenarios for lock, boot mode, masking, sleep and feed.
module sim_staged_watchdog;

    localparam logic [31:0] KEYV = 32'h50D83AA1;
    localparam int A_CTRL = 0, A_ACTS = 1, A_TMO0 = 2, A_FEED = 6, A_KEY = 7;
    localparam int A_IRQEN = 8, A_IRQST = 9, A_IRQCLR = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        sleep_i = 1'b0;
    logic [1:0]  dly_sel_i = 2'd0;
    logic        irq_o;
    logic [1:0]  cpu_rst_o;
    logic        sys_rst_o, aon_rst_o, chip_rst_o;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    always #4 clk = ~clk;

    staged_watchdog #(.TMO_RESET(32'd20)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sleep_i(sleep_i),
        .dly_sel_i(dly_sel_i), .irq_o(irq_o), .cpu_rst_o(cpu_rst_o),
        .sys_rst_o(sys_rst_o), .aon_rst_o(aon_rst_o), .chip_rst_o(chip_rst_o)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 4'(a); reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = 4'(a);
        #1 d = reg_rdata;
    endtask

    function automatic int exp_len(input int code);
        int ns [8] = '{100, 200, 300, 400, 500, 800, 1600, 3200};
        return (ns[code] + 7) / 8;
    endfunction

    // Stop and clear, then reprogram.
    task automatic quiesce();
        wr(A_CTRL, 32'h0);
        wr(A_IRQCLR, 32'h1);
    endtask

    task automatic arm(input logic [31:0] c);
        wr(A_CTRL, c);
        wr(A_FEED, 32'h1);
    endtask

    // Cycles from the feed until irq_o rises; sleep high on [from, to).
    task automatic measure_irq(input int from, input int to, output int n);
        n = -1;
        for (int k = 1; k <= 3000; k++) begin
            @(negedge clk);
            if (irq_o) begin n = k; break; end
            sleep_i = (k >= from && k < to);
        end
        sleep_i = 1'b0;
    endtask

    // Watchdog timer for the bench itself.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog: bench hung");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        int n;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // Reset state
        rd(A_CTRL, d);  chk("R6 ctrl reset", d, 2);
        rd(A_TMO0, d);  chk("R6 timeout reset", d, 20);
        chk("R11 irq reset", irq_o, 0);
        chk("R1 resets idle", {cpu_rst_o, sys_rst_o, aon_rst_o, chip_rst_o}, 0);

        // Lock behaviour
        wr(A_CTRL, 32'h1);
        rd(A_CTRL, d);  chk("R5 locked write ignored", d, 2);
        wr(A_KEY, KEYV);
        wr(A_TMO0 + 3, 32'd99);
        rd(A_TMO0 + 3, d); chk("R5 unlocked write", d, 99);
        wr(A_TMO0 + 3, 32'd20);
        wr(A_KEY, 32'h12345678);
        wr(A_TMO0 + 3, 32'd77);
        rd(A_TMO0 + 3, d); chk("R5 relock", d, 20);
        wr(A_KEY, KEYV);

        // Boot mode fires with run enable off
        quiesce();
        wr(A_ACTS, 32'd1);
        wr(A_IRQEN, 32'h1);
        arm(32'h2);
        measure_irq(0, 0, n);
        chk("R6 boot mode fires", n, 40);
        quiesce();
        wr(A_FEED, 32'h1);
        repeat (200) @(negedge clk);
        chk("R6 both enables off", irq_o, 0);

        // Interrupt masking
        wr(A_IRQEN, 32'h0);
        arm(32'h1);
        repeat (45) @(negedge clk);
        chk("R11 masked line", irq_o, 0);
        rd(A_IRQST, d); chk("R11 status set", d, 1);
        wr(A_IRQEN, 32'h1);
        chk("R11 unmasked line", irq_o, 1);
        wr(A_IRQCLR, 32'h1);
        chk("R11 cleared", irq_o, 0);

        // Sleep pause stretches stage 0 by the sleep length
        quiesce();
        arm(32'h5);
        measure_irq(2, 12, n);
        chk("R9 pause in sleep", n, 50);
        quiesce();
        arm(32'h1);
        measure_irq(1, 3000, n);
        chk("R9 sleep ignored without pause", n, 40);

        // Feed inside stage 1 (stage 0 off still advances)
        quiesce();
        wr(A_ACTS, 32'h8);
        wr(A_TMO0 + 1, 32'd30);
        arm(32'h1);
        repeat (50) @(negedge clk);
        wr(A_FEED, 32'h1);
        measure_irq(0, 0, n);
        chk("R4 feed restarts at stage 0", n, 70);

        // Sweep: strap, length codes and CPU masks
        for (int it = 0; it < 8; it++) begin
            int l0, s, cl, sl, msk, k;
            int rise [6];
            int fall [6];
            int wrap_irq;
            logic [5:0] prev, now;
            cl = it; sl = 7 - it; msk = it % 4;
            l0 = 3 << (1 + (it % 4));
            s = l0 + 450 + 460 + 470;
            quiesce();
            dly_sel_i = 2'(it % 4);
            wr(A_ACTS, 32'd2257);
            wr(A_TMO0, 32'd3);
            wr(A_TMO0 + 1, 32'd450);
            wr(A_TMO0 + 2, 32'd460);
            wr(A_TMO0 + 3, 32'd470);
            arm(32'h1 | 32'(msk << 4) | 32'(cl << 6) | 32'(sl << 9));
            for (int j = 0; j < 6; j++) begin rise[j] = -1; fall[j] = -1; end
            wrap_irq = -1;
            prev = '0;
            for (k = 1; k <= s + l0 + 420; k++) begin
                @(negedge clk);
                now = {chip_rst_o, aon_rst_o, sys_rst_o, cpu_rst_o[1], cpu_rst_o[0], irq_o};
                for (int j = 0; j < 6; j++) begin
                    if (now[j] && !prev[j] && rise[j] < 0) rise[j] = k;
                    if (!now[j] && prev[j] && fall[j] < 0) fall[j] = k;
                end
                if (k > l0 + 2 && irq_o && wrap_irq < 0) wrap_irq = k;
                prev = now;
                if (k == l0 + 1) begin reg_we = 1'b1; reg_addr = 4'(A_IRQCLR); reg_wdata = 32'h1; end
                if (k == l0 + 2) reg_we = 1'b0;
            end
            chk($sformatf("R2 stage0 scale sel=%0d", it % 4), rise[0], l0);
            for (int c = 0; c < 2; c++) begin
                if (msk[c]) begin
                    chk($sformatf("R8 cpu%0d rise", c), rise[1 + c], l0 + 450);
                    chk($sformatf("R7 cpu%0d width code %0d", c, cl),
                        fall[1 + c] - rise[1 + c], exp_len(cl));
                end else begin
                    chk($sformatf("R8 cpu%0d disabled", c), rise[1 + c], -1);
                end
            end
            chk("R3 system reset at stage 2 end", rise[3], l0 + 910);
            chk($sformatf("R7 sys width code %0d", sl), fall[3] - rise[3], exp_len(sl));
            chk("R1 always-on reset at stage 3 end", rise[4], s);
            chk("R1 always-on width", fall[4] - rise[4], exp_len(sl));
            chk("R3 wrap to stage 0", wrap_irq, s + l0);
            chk("R10 chip reset off", rise[5], -1);
            quiesce();
            repeat (420) @(negedge clk);
        end

        // Chip reset alongside a system reset
        begin
            int cr, cf, sr, sf;
            cr = -1; cf = -1; sr = -1; sf = -1;
            dly_sel_i = 2'd0;
            wr(A_ACTS, 32'd3);
            arm(32'h1 | 32'h8 | (32'd7 << 12));
            for (int k = 1; k <= 30; k++) begin
                @(negedge clk);
                if (chip_rst_o && cr < 0) cr = k;
                if (!chip_rst_o && cr > 0 && cf < 0) cf = k;
                if (sys_rst_o && sr < 0) sr = k;
                if (!sys_rst_o && sr > 0 && sf < 0) sf = k;
            end
            chk("R10 chip rise", cr, 6);
            chk("R10 chip width", cf - cr, 7);
            chk("R1 sys action", sr, 6);
            chk("R7 sys width code 0", sf - sr, 13);
        end

        // Action code 5 behaves as off
        quiesce();
        wr(A_ACTS, 32'd5);
        arm(32'h9);
        begin
            int seen;
            seen = 0;
            for (int k = 1; k <= 40; k++) begin
                @(negedge clk);
                if ({irq_o, cpu_rst_o, sys_rst_o, aon_rst_o, chip_rst_o} != '0) seen = 1;
            end
            chk("R1 code 5 no action", seen, 0);
            rd(A_IRQST, d);
            chk("R1 code 5 no status", d, 0);
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule